// File: doc/BRIEF.md
# SDRAM Read-Latency and Byte-Mask Data Path

This block sits between the array side of a 16-bit synchronous DRAM model and its data pins. Each word the array side hands over, flagged valid, is held back by the programmed read latency (1, 2 or 3 clock edges) before it drives the data outputs, together with a per-byte output enable. Two byte-mask inputs gate the data path. A read mask blanks the read slot two accepted edges after it is sampled. A write mask blocks the write byte in the same cycle, because write data is taken on the same edge as the write command.

A row close (precharge) or a burst stop arriving during a read cuts off the words still in flight. The cutoff point depends on the latency. A low clock-enable suspends the following edge: all state freezes and that edge's inputs are ignored. The latency setting is taken from a 3-bit mode key only while no read word is in flight.

Top module: `sdram_dq_pipe`

## Requirements
- R1: The latency key `cl_code` loads latency 1, 2 or 3 from codes 3'b001, 3'b010 and 3'b011. Every other code is ignored and the previous latency stays in force. After reset the latency is 2.
- R2: A word with `rd_valid` high at accepted edge n is captured by the receiver at accepted edge n+L, where L is the latency. It is on `dq_o`, with its byte enables high, during the cycle after accepted edge n+L-1.
- R3: `dqm[b]` high at accepted edge n forces `rd_oe[b]` low in the cycle after accepted edge n+1. That is the read slot captured at edge n+2.
- R4: `dqm[0]` and `rd_oe[0]` belong to data bits 7..0. `dqm[1]` and `rd_oe[1]` belong to data bits 15..8. A mask on one byte leaves the other byte unchanged.
- R5: `wr_be[b]` is high exactly when `wr_stb` is high, `dqm[b]` is low, and the coming edge is not suspended.
- R6: A byte whose output enable is low, whether masked or in an empty slot, reads as zero on `dq_o`.
- R7: A precharge strobe at accepted edge n drops every in-flight or incoming word whose capture edge is n+1 or later at latency 1. At latency 2 or 3 it drops every such word whose capture edge is n+2 or later.
- R8: A burst-stop strobe at accepted edge n drops only the word whose capture edge would be n+L. That is the word arriving on the same edge. Words already in flight still appear.
- R9: `cke` low at edge T makes edge T+1 a suspended edge. At a suspended edge no register changes, `rd_oe` and `dq_o` hold their values, and `wr_be` is low in the cycle leading to it.
- R10: With both mask bits held high on the edges before a write, both read output enables stay low in the write cycle and in the cycle before it.
- R11: A latency key presented while any read word is in flight takes effect only at the first accepted edge at which the pipeline is empty. The key must still be presented at that edge.
- R12: Right after reset, `rd_oe`, `dq_o` and `wr_be` are zero for idle inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends the next edge |
| cl_code | input | 3 | Read latency key |
| rd_valid | input | 1 | Array-side read word valid |
| rd_data | input | 16 | Array-side read word |
| dqm | input | 2 | Byte masks, bit 1 upper byte |
| wr_stb | input | 1 | Write command strobe |
| pre_stb | input | 1 | Precharge (row close) strobe |
| stop_stb | input | 1 | Burst-stop strobe |
| dq_o | output | 16 | Read data toward the pins |
| rd_oe | output | 2 | Per-byte read output enable |
| wr_be | output | 2 | Per-byte write enable |

## Verification
The bench builds the block with its default parameters: 16-bit data, maximum latency 3 and a long precharge cutoff of 2. With these values all three latencies are in use, and latency 3 is the only setting where the precharge cutoff and the burst-stop cutoff give different results. The default reset latency of 2 lets the first reads run before any key is loaded. The bench uses it to show that a key arriving mid-burst is held off until the pipeline is empty.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  localparam int CL_CODE_W = 3;

  typedef enum logic [1:0] {
    CUT_NONE = 2'd0,
    CUT_STOP = 2'd1,
    CUT_PRE  = 2'd2
  } cut_e;

  function automatic logic cl_legal(input logic [CL_CODE_W-1:0] code, input int max_cl);
    return (int'(code) >= 1) && (int'(code) <= max_cl);
  endfunction

endpackage

// File: rtl/sdq_rst_sync.sv
module sdq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sdq_suspend.sv
module sdq_suspend (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic step_en
);
  logic cke_q;
  logic cke_d;

  always_comb begin
    cke_d = cke;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke_d;
  end

  assign step_en = cke_q;
endmodule

// File: rtl/sdq_cl_reg.sv
module sdq_cl_reg
  import sdq_pkg::*;
#(
  parameter int MAX_CL = 3,
  parameter int RST_CL = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  logic                 pipe_empty,
  input  logic [CL_CODE_W-1:0] cl_code,
  output logic [CL_CODE_W-1:0] cl
);
  logic [CL_CODE_W-1:0] cl_q;
  logic [CL_CODE_W-1:0] cl_d;

  always_comb begin
    cl_d = cl_q;
    if (step_en && pipe_empty && cl_legal(cl_code, MAX_CL)) cl_d = cl_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cl_q <= CL_CODE_W'(RST_CL);
    else        cl_q <= cl_d;
  end

  assign cl = cl_q;
endmodule

// File: rtl/sdq_rd_pipe.sv
module sdq_rd_pipe
  import sdq_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_CL  = 3,
  parameter int PRE_CUT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  logic [CL_CODE_W-1:0] cl,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_data,
  input  cut_e                 cut_sel,
  output logic                 tap_valid,
  output logic [DW-1:0]        tap_data,
  output logic                 pipe_empty
);
  logic [MAX_CL-1:0]         vld_q, vld_d;
  logic [MAX_CL-1:0][DW-1:0] dat_q, dat_d;
  logic [MAX_CL-1:0]         kill;
  int                        clv;
  int                        cut;

  // Cutoff distance: words captured at or after (edge + cut) are dropped
  always_comb begin
    clv = int'(cl);
    cut = 0;
    case (cut_sel)
      CUT_PRE:  cut = (clv > PRE_CUT) ? PRE_CUT : clv;
      CUT_STOP: cut = clv;
      default:  cut = 0;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < MAX_CL; gi++) begin : g_stage
      logic          sh_v;
      logic [DW-1:0] sh_d;
      if (gi == 0) begin : g_head
        assign sh_v = in_valid;
        assign sh_d = in_data;
      end else begin : g_body
        assign sh_v = vld_q[gi-1];
        assign sh_d = dat_q[gi-1];
      end

      always_comb begin
        kill[gi] = (cut != 0) && (gi <= clv - cut);
        if (step_en) begin
          vld_d[gi] = sh_v && (gi < clv) && !kill[gi];
          dat_d[gi] = sh_d;
        end else begin
          vld_d[gi] = vld_q[gi];
          dat_d[gi] = dat_q[gi];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  always_comb begin
    tap_valid = 1'b0;
    tap_data  = '0;
    for (int i = 0; i < MAX_CL; i++) begin
      if (clv == i + 1) begin
        tap_valid = vld_q[i];
        tap_data  = dat_q[i];
      end
    end
  end

  assign pipe_empty = ~|vld_q;
endmodule

// File: rtl/sdq_lane.sv
module sdq_lane #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          mask_in,
  input  logic          wr_stb,
  input  logic          tap_valid,
  input  logic [BW-1:0] tap_byte,
  output logic          oe,
  output logic [BW-1:0] byte_o,
  output logic          we
);
  logic m1_q, m1_d;
  logic m2_q, m2_d;

  // Two-stage mask delay: read slot two edges after sampling
  always_comb begin
    m1_d = step_en ? mask_in : m1_q;
    m2_d = step_en ? m1_q    : m2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q <= 1'b0;
      m2_q <= 1'b0;
    end else begin
      m1_q <= m1_d;
      m2_q <= m2_d;
    end
  end

  always_comb begin
    oe     = tap_valid && !m2_q;
    byte_o = oe ? tap_byte : '0;
    we     = wr_stb && step_en && !mask_in;
  end
endmodule

// File: rtl/sdram_dq_pipe.sv
module sdram_dq_pipe
  import sdq_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_CL  = 3,
  parameter int RST_CL  = 2,
  parameter int PRE_CUT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic [CL_CODE_W-1:0] cl_code,
  input  logic                 rd_valid,
  input  logic [DW-1:0]        rd_data,
  input  logic [DW/8-1:0]      dqm,
  input  logic                 wr_stb,
  input  logic                 pre_stb,
  input  logic                 stop_stb,
  output logic [DW-1:0]        dq_o,
  output logic [DW/8-1:0]      rd_oe,
  output logic [DW/8-1:0]      wr_be
);
  localparam int BYTES = DW / 8;

  logic                 rst_n_i;
  logic                 step_en;
  logic                 pipe_empty;
  logic [CL_CODE_W-1:0] cl;
  logic                 tap_valid;
  logic [DW-1:0]        tap_data;
  cut_e                 cut_sel;

  always_comb begin
    if (pre_stb)       cut_sel = CUT_PRE;
    else if (stop_stb) cut_sel = CUT_STOP;
    else               cut_sel = CUT_NONE;
  end

  sdq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sdq_suspend u_susp (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .cke     (cke),
    .step_en (step_en)
  );

  sdq_cl_reg #(.MAX_CL(MAX_CL), .RST_CL(RST_CL)) u_cl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .step_en    (step_en),
    .pipe_empty (pipe_empty),
    .cl_code    (cl_code),
    .cl         (cl)
  );

  sdq_rd_pipe #(.DW(DW), .MAX_CL(MAX_CL), .PRE_CUT(PRE_CUT)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .step_en    (step_en),
    .cl         (cl),
    .in_valid   (rd_valid),
    .in_data    (rd_data),
    .cut_sel    (cut_sel),
    .tap_valid  (tap_valid),
    .tap_data   (tap_data),
    .pipe_empty (pipe_empty)
  );

  genvar gb;
  generate
    for (gb = 0; gb < BYTES; gb++) begin : g_lane
      sdq_lane #(.BW(8)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n_i),
        .step_en   (step_en),
        .mask_in   (dqm[gb]),
        .wr_stb    (wr_stb),
        .tap_valid (tap_valid),
        .tap_byte  (tap_data[gb*8 +: 8]),
        .oe        (rd_oe[gb]),
        .byte_o    (dq_o[gb*8 +: 8]),
        .we        (wr_be[gb])
      );
    end
  endgenerate
endmodule

// File: rtl/sdq_chk.sv
module sdq_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cke,
  input logic [DW/8-1:0] dqm,
  input logic            wr_stb,
  input logic [DW-1:0]   dq_o,
  input logic [DW/8-1:0] rd_oe,
  input logic [DW/8-1:0] wr_be
);
  // R9
  hold_on_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ##1 ($stable(rd_oe) && $stable(dq_o)));

  // R9
  no_write_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (wr_be == '0));

  // R10
  turnaround_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && cke && (&dqm)) ##1 (cke && (&dqm)) |=> ##1 (rd_oe == '0));

  genvar gb;
  generate
    for (gb = 0; gb < DW/8; gb++) begin : g_byte
      // R6
      zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe[gb] |-> (dq_o[gb*8 +: 8] == 8'h00));

      // R5
      write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_be[gb] |-> (wr_stb && !dqm[gb]));

      // R3
      read_mask_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cke) && cke && dqm[gb]) |=> ##1 !rd_oe[gb]);
    end
  endgenerate
endmodule

bind sdram_dq_pipe sdq_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cke    (cke),
  .dqm    (dqm),
  .wr_stb (wr_stb),
  .dq_o   (dq_o),
  .rd_oe  (rd_oe),
  .wr_be  (wr_be)
);

// File: tb/sdram_dq_pipe_tb.sv
module sdram_dq_pipe_tb;
  logic        clk;
  logic        rst_n;
  logic        cke;
  logic [2:0]  cl_code;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [1:0]  dqm;
  logic        wr_stb;
  logic        pre_stb;
  logic        stop_stb;
  logic [15:0] dq_o;
  logic [1:0]  rd_oe;
  logic [1:0]  wr_be;

  int    checks;
  int    errors;
  string tag;

  // Reference model state, indexed by accepted-edge number modulo 16
  int          n_acc;
  int          cl_m;
  bit          ckp;
  bit          sv [16];
  logic [15:0] sd [16];
  logic [1:0]  sm [16];
  logic [2:0]  cur_code;

  sdram_dq_pipe u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cl_code  (cl_code),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .dqm      (dqm),
    .wr_stb   (wr_stb),
    .pre_stb  (pre_stb),
    .stop_stb (stop_stb),
    .dq_o     (dq_o),
    .rd_oe    (rd_oe),
    .wr_be    (wr_be)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [1:0] exp_oe();
    int idx = (n_acc + 1) % 16;
    return sv[idx] ? ~sm[idx] : 2'b00;
  endfunction

  function automatic logic [15:0] exp_dq();
    int idx = (n_acc + 1) % 16;
    logic [1:0] oe = exp_oe();
    return {oe[1] ? sd[idx][15:8] : 8'h00, oe[0] ? sd[idx][7:0] : 8'h00};
  endfunction

  task automatic cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic k, input logic [2:0] code, input logic v,
                            input logic [15:0] d, input logic [1:0] m,
                            input logic p, input logic s);
    if (ckp) begin
      bit empty = 1'b1;
      n_acc++;
      for (int j = 0; j < cl_m; j++) if (sv[(n_acc + j) % 16]) empty = 1'b0;
      sv[n_acc % 16] = 1'b0;
      sm[n_acc % 16] = 2'b00;
      if (empty && code >= 3'd1 && code <= 3'd3) cl_m = int'(code);
      sm[(n_acc + 2) % 16] = m;
      if (v) begin
        sv[(n_acc + cl_m) % 16] = 1'b1;
        sd[(n_acc + cl_m) % 16] = d;
      end
      if (p || s) begin
        int dcut = p ? ((cl_m < 2) ? cl_m : 2) : cl_m;
        for (int j = dcut; j <= cl_m; j++) sv[(n_acc + j) % 16] = 1'b0;
      end
    end
    ckp = k;
  endtask

  task automatic tick(input logic k, input logic v, input logic [15:0] d,
                      input logic [1:0] m, input logic w, input logic p, input logic s);
    @(negedge clk);
    cmp("rd_oe", {14'd0, rd_oe}, {14'd0, exp_oe()});
    cmp("dq_o", dq_o, exp_dq());
    cke = k; cl_code = cur_code; rd_valid = v; rd_data = d;
    dqm = m; wr_stb = w; pre_stb = p; stop_stb = s;
    #1;
    cmp("wr_be", {14'd0, wr_be}, {14'd0, ({2{w & ckp}} & ~m)});
    model_step(k, cur_code, v, d, m, p, s);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) tick(1'b1, 1'b0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic burst(input int len, input logic [15:0] base, input int cut_at, input bit use_pre);
    for (int i = 0; i < len; i++)
      tick(1'b1, 1'b1, base + 16'(i), 2'b00, 1'b0,
           (i == cut_at) && use_pre, (i == cut_at) && !use_pre);
    idle(5);
  endtask

  initial begin
    int cnt;
    bit in_burst;
    void'($urandom(32'h5eed));
    checks = 0; errors = 0;
    n_acc = 0; cl_m = 2; ckp = 1'b1; cur_code = 3'b010;
    for (int i = 0; i < 16; i++) begin sv[i] = 0; sd[i] = '0; sm[i] = '0; end
    rst_n = 1'b0; cke = 1'b1; cl_code = 3'b010; rd_valid = 0; rd_data = '0;
    dqm = '0; wr_stb = 0; pre_stb = 0; stop_stb = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state with idle inputs
    tag = "R12";
    idle(2);

    // R2: latency 2 out of reset, then each legal key (R1)
    tag = "R2";
    burst(1, 16'hA5C3, -1, 0);
    for (int c = 1; c <= 3; c++) begin
      tag = "R1";
      cur_code = 3'(c);
      idle(2);
      tag = "R2";
      burst(4, 16'h1000 * 16'(c), -1, 0);
    end

    // R1: reserved keys leave latency at 3
    tag = "R1";
    cur_code = 3'b000; idle(2); burst(2, 16'h2200, -1, 0);
    cur_code = 3'b111; idle(2); burst(2, 16'h2300, -1, 0);

    // R11: key changed mid-burst is deferred until the pipe drains
    tag = "R11";
    cur_code = 3'b010; idle(2);
    for (int i = 0; i < 6; i++) begin
      if (i == 2) cur_code = 3'b001;
      tick(1'b1, 1'b1, 16'h3300 + 16'(i), 2'b00, 1'b0, 1'b0, 1'b0);
    end
    idle(3); burst(3, 16'h3400, -1, 0);

    // R3 / R4: per-byte read masks two edges ahead
    tag = "R3";
    cur_code = 3'b010; idle(2);
    for (int i = 0; i < 8; i++)
      tick(1'b1, 1'b1, 16'hBE00 + 16'(i), (i == 2) ? 2'b01 : ((i == 5) ? 2'b10 : 2'b00),
           1'b0, 1'b0, 1'b0);
    idle(4);
    tag = "R4";
    for (int i = 0; i < 6; i++)
      tick(1'b1, 1'b1, 16'hF00F ^ 16'(i * 17), 2'(i), 1'b0, 1'b0, 1'b0);
    idle(4);

    // R5: write byte enables follow the same-cycle mask
    tag = "R5";
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 16'h0, 2'(i), 1'b1, 1'b0, 1'b0);
    idle(1);

    // R7 / R8: precharge and burst-stop cutoff at every latency
    for (int c = 1; c <= 3; c++) begin
      cur_code = 3'(c);
      tag = "R1"; idle(3);
      tag = "R7"; burst(8, 16'h7000 + 16'(c << 8), 3, 1);
      tag = "R8"; burst(8, 16'h8000 + 16'(c << 8), 3, 0);
    end

    // R9: clock suspension mid-burst and during writes
    tag = "R9";
    cur_code = 3'b011; idle(2);
    for (int i = 0; i < 10; i++)
      tick((i != 3) && (i != 4) && (i != 7), 1'b1, 16'h9900 + 16'(i), 2'b00,
           (i == 4) || (i == 5), 1'b0, 1'b0);
    idle(5);

    // R10: read, masks high for three edges, then a write
    tag = "R10";
    cur_code = 3'b010; idle(2);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 16'hAA00 + 16'(i), 2'b00, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 16'h0, 2'b11, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 16'h0, 2'b00, 1'b1, 1'b0, 1'b0);
    idle(3);

    // R6 and all others: constrained random traffic
    tag = "R6";
    cnt = 0; in_burst = 0;
    for (int i = 0; i < 1500; i++) begin
      logic k, v, w, p, s;
      logic [1:0] m;
      if (($urandom % 20) == 0) cur_code = 3'($urandom % 8);
      if (cnt == 0) begin
        in_burst = ($urandom % 3) != 0;
        cnt = 1 + int'($urandom % 8);
      end
      cnt--;
      k = ($urandom % 10) != 0;
      v = in_burst;
      m = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      w = ($urandom % 5) == 0;
      p = ($urandom % 30) == 0;
      s = ($urandom % 30) == 0;
      tick(k, v, 16'($urandom), m, w, p, s);
    end
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule